// File: doc/BRIEF.md
# Interrupt distributor register bank

This block holds the per-interrupt configuration of a small interrupt controller and turns raw interrupt lines into per-processor candidate lists. It serves 64 interrupt IDs by default. IDs 0–31 are private: each processor has its own input lines and its own enable, pending and active state for them. IDs 32–63 are shared, with a single copy of each bit and an 8-bit target mask that routes the interrupt to processors. Software reaches the block over a simple 32-bit register bus with word addresses. Every bus access carries the index of the requesting processor, and that index selects which private bank is reached.

Each input line passes through a two-stage synchronizer. A configuration bit then decides how the synchronized line becomes pending. In edge mode a rising edge sets a sticky pending flag. In level mode the line is pending for as long as it is high. A processor interface reports that it has taken an interrupt with an acknowledge pulse, which marks the interrupt active. A later completion pulse clears the active state. An interrupt is offered to a processor on `cand_o` only when all of these hold: the global enable is set, the interrupt is enabled, it is pending, it is not active, and, for a shared ID, the processor's bit in its target mask is set. Priority values are stored and can be read back. The block does not arbitrate between candidates by priority.

Top module: `irqd_dist`

## Requirements
- R1: A write to a set-enable word (word address 0x08 + w, covering IDs 32w..32w+31, bit n%32 for ID n) enables every interrupt whose bit is 1. Bits written as 0 leave their enables unchanged.
- R2: A write to a clear-enable word (0x0C + w) disables every interrupt whose bit is 1. Bits written as 0 have no effect. A read of either the set-enable word or the clear-enable word returns the current enable bits.
- R3: Configuration words sit at 0x20 + k and cover IDs 16k..16k+15. Bit 2(n%16)+1 of the word is the mode of ID n: 1 selects rising-edge and 0 selects level. Bit 2(n%16) always reads 0.
- R4: Writes to the configuration fields of IDs 0–15 are ignored. Those fields read 0, and those IDs behave as level interrupts.
- R5: Priority words sit at 0x40 + n/4 and target words at 0x60 + n/4. The value for ID n occupies byte lane n%4, bits 8(n%4)+7..8(n%4). Priorities and shared targets read back as written.
- R6: Enable, pending and active state for IDs 0–31 is banked per processor, and `bus_cpu` selects the bank. One processor's accesses to these bits never change or show another processor's bank, and a private line only raises a candidate for its own processor.
- R7: For IDs 0–31, every byte of a target read holds the one-hot mask 1 << bus_cpu. Target writes to those IDs are ignored.
- R8: The read-only type word at 0x01 returns NIRQ/32 − 1 in bits 4:0, which is 1 for 64 interrupts. All other bits read 0.
- R9: Bit 0 of the control word at 0x00 is a global enable. While it is 0, every bit of `cand_o` is 0.
- R10: In edge mode, a 0→1 transition of the synchronized line sets a pending flag. The flag stays set after the line falls and is cleared by an acknowledge of that ID. Pending state reads at 0x10 + w.
- R11: In level mode, an interrupt is pending while its synchronized line is high and it is not active. It becomes a candidate again after completion if the line is still high.
- R12: An acknowledge (`ack_vld[c]` with `ack_id`) marks the ID active, and a completion (`eoi_vld[c]` with `eoi_id`) clears it. Active state reads at 0x14 + w. `cand_o[c*NIRQ+n]` requires the global enable, the enable bit, the pending state and no active state, and for a shared ID it also requires bit c of the target mask.
- R13: After reset the global enable, all enables, pending and active state, all mode bits, all priorities and all shared targets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPUW | Index of the processor making the bus access |
| bus_addr | input | AW | Word address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr and bus_cpu, combinational |
| priv_in | input | NCPU*NPRIV | Private interrupt lines, processor c at bits c*NPRIV.. |
| shr_in | input | NIRQ-NPRIV | Shared interrupt lines, bit j is ID NPRIV+j |
| ack_vld | input | NCPU | Acknowledge pulse per processor |
| ack_id | input | NCPU*IDW | ID acknowledged, per processor |
| eoi_vld | input | NCPU | Completion pulse per processor |
| eoi_id | input | NCPU*IDW | ID completed, per processor |
| cand_o | output | NCPU*NIRQ | Candidate interrupts, processor c at bits c*NIRQ.. |

## Verification
The hardest case to reach is a level interrupt whose line stays high across an acknowledge and a completion. The bench has to show that the candidate disappears while the interrupt is active and comes back afterwards without a new edge. The stimulus holds the line high on purpose, pulses the acknowledge and completion inputs, and toggles the global enable between them. An edge interrupt is checked after its line has already fallen, so the only thing that can keep it pending is the sticky flag. Its candidate is checked on the routed processor and also on a processor that is not routed. A seeded random series of set-enable, clear-enable, mode, priority and target writes, issued from both processor indices, is then read back against a bench model of the banked and shared state.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // Word addresses of the register regions
    localparam int A_CTRL  = 'h00;
    localparam int A_TYPE  = 'h01;
    localparam int A_ENSET = 'h08;
    localparam int A_ENCLR = 'h0C;
    localparam int A_PEND  = 'h10;
    localparam int A_ACT   = 'h14;
    localparam int A_CFG   = 'h20;
    localparam int A_PRIO  = 'h40;
    localparam int A_TGT   = 'h60;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_ENSET, RG_ENCLR,
        RG_PEND, RG_ACT, RG_CFG, RG_PRIO, RG_TGT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [4:0] idx;
    } dec_t;

    // Map a word address onto a region and a word index inside it
    function automatic dec_t decode(input int a, input int n_en,
                                    input int n_cfg, input int n_wd);
        dec_t r;
        r.sel = RG_NONE;
        r.idx = '0;
        if (a == A_CTRL) begin
            r.sel = RG_CTRL;
        end else if (a == A_TYPE) begin
            r.sel = RG_TYPE;
        end else if (a >= A_ENSET && a < A_ENSET + n_en) begin
            r.sel = RG_ENSET; r.idx = 5'(a - A_ENSET);
        end else if (a >= A_ENCLR && a < A_ENCLR + n_en) begin
            r.sel = RG_ENCLR; r.idx = 5'(a - A_ENCLR);
        end else if (a >= A_PEND && a < A_PEND + n_en) begin
            r.sel = RG_PEND; r.idx = 5'(a - A_PEND);
        end else if (a >= A_ACT && a < A_ACT + n_en) begin
            r.sel = RG_ACT; r.idx = 5'(a - A_ACT);
        end else if (a >= A_CFG && a < A_CFG + n_cfg) begin
            r.sel = RG_CFG; r.idx = 5'(a - A_CFG);
        end else if (a >= A_PRIO && a < A_PRIO + n_wd) begin
            r.sel = RG_PRIO; r.idx = 5'(a - A_PRIO);
        end else if (a >= A_TGT && a < A_TGT + n_wd) begin
            r.sel = RG_TGT; r.idx = 5'(a - A_TGT);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqd_line_sync.sv
module irqd_line_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/irqd_src_cell.sv
module irqd_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic line_lvl,
    input  logic line_rise,
    input  logic edge_mode,
    input  logic en_set,
    input  logic en_clr,
    input  logic act_set,
    input  logic act_clr,
    output logic en_o,
    output logic pend_o,
    output logic act_o
);
    logic en_q, latch_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            latch_q <= 1'b0;
            act_q   <= 1'b0;
        end else begin
            en_q  <= (en_q & ~en_clr) | en_set;
            act_q <= (act_q & ~act_clr) | act_set;
            if (!edge_mode)     latch_q <= 1'b0;
            else if (line_rise) latch_q <= 1'b1;
            else if (act_set)   latch_q <= 1'b0;
        end
    end

    assign en_o   = en_q;
    assign act_o  = act_q;
    assign pend_o = edge_mode ? latch_q : (line_lvl & ~act_q);

    a_r1_set_enables: assert property (@(posedge clk) disable iff (rst)
        en_set |=> en_o);
    a_r2_clear_disables: assert property (@(posedge clk) disable iff (rst)
        (en_clr && !en_set) |=> !en_o);
    a_r10_edge_captured: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && line_rise) |=> latch_q);
    a_r12_ack_marks_active: assert property (@(posedge clk) disable iff (rst)
        act_set |=> act_o);
    a_r12_done_clears_active: assert property (@(posedge clk) disable iff (rst)
        (act_clr && !act_set) |=> !act_o);
endmodule

// File: rtl/irqd_dist.sv
module irqd_dist
    import irqd_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NIRQ  = 64,
    parameter int NPRIV = 32,
    parameter int NFIX  = 16,
    parameter int AW    = 8,
    localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IDW  = $clog2(NIRQ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CPUW-1:0]       bus_cpu,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NCPU*NPRIV-1:0] priv_in,
    input  logic [NIRQ-NPRIV-1:0] shr_in,
    input  logic [NCPU-1:0]       ack_vld,
    input  logic [NCPU*IDW-1:0]   ack_id,
    input  logic [NCPU-1:0]       eoi_vld,
    input  logic [NCPU*IDW-1:0]   eoi_id,
    output logic [NCPU*NIRQ-1:0]  cand_o
);
    localparam int NSHR  = NIRQ - NPRIV;
    localparam int NEW   = NIRQ / 32;
    localparam int NCW   = NIRQ / 16;
    localparam int NBW   = NIRQ / 4;
    localparam int NLINE = NCPU * NPRIV + NSHR;

    dec_t dq;
    logic cpu_ok;
    logic gctl_q;
    logic wr_enset, wr_enclr, wr_cfg, wr_prio, wr_tgt;
    logic [7:0] cpu_hot;

    logic [NLINE-1:0] line_s, line_r;
    logic [NCPU*NPRIV-1:0] p_en, p_pend, p_act;
    logic [NSHR-1:0]       s_en, s_pend, s_act;
    logic [NIRQ-1:0]       cfg_edge;
    logic [NIRQ-1:0][7:0]  prio_q;
    logic [NIRQ-1:0][7:0]  tgt_view;
    logic [NIRQ-1:0]       en_view, pd_view, ac_view;

    assign dq       = decode(int'(bus_addr), NEW, NCW, NBW);
    assign cpu_ok   = (int'(bus_cpu) < NCPU);
    assign wr_enset = bus_wr && (dq.sel == RG_ENSET);
    assign wr_enclr = bus_wr && (dq.sel == RG_ENCLR);
    assign wr_cfg   = bus_wr && (dq.sel == RG_CFG);
    assign wr_prio  = bus_wr && (dq.sel == RG_PRIO);
    assign wr_tgt   = bus_wr && (dq.sel == RG_TGT);

    always_comb begin
        cpu_hot = '0;
        for (int k = 0; k < NCPU; k++)
            cpu_hot[k] = cpu_ok && (int'(bus_cpu) == k);
    end

    always_ff @(posedge clk) begin
        if (rst)                               gctl_q <= 1'b0;
        else if (bus_wr && dq.sel == RG_CTRL)  gctl_q <= bus_wdata[0];
    end

    irqd_line_sync #(.W(NLINE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({shr_in, priv_in}),
        .lvl  (line_s),
        .rise (line_r)
    );

    for (genvar n = 0; n < NIRQ; n++) begin : g_id
        localparam int EW = n / 32;
        localparam int EB = n % 32;
        localparam int CW = n / 16;
        localparam int CB = 2 * (n % 16) + 1;
        localparam int BW = n / 4;
        localparam int BL = 8 * (n % 4);

        logic [7:0] pr_q;
        always_ff @(posedge clk) begin
            if (rst)                                pr_q <= '0;
            else if (wr_prio && int'(dq.idx) == BW) pr_q <= bus_wdata[BL +: 8];
        end
        assign prio_q[n] = pr_q;

        if (n >= NFIX) begin : g_cfg
            logic ce_q;
            always_ff @(posedge clk) begin
                if (rst)                               ce_q <= 1'b0;
                else if (wr_cfg && int'(dq.idx) == CW) ce_q <= bus_wdata[CB];
            end
            assign cfg_edge[n] = ce_q;
        end else begin : g_fixed
            assign cfg_edge[n] = 1'b0;
        end

        if (n < NPRIV) begin : g_priv
            assign tgt_view[n] = cpu_hot;
            for (genvar c = 0; c < NCPU; c++) begin : g_cpu
                localparam int LI = c * NPRIV + n;
                logic c_set, c_clr, c_ack, c_eoi;
                assign c_set = wr_enset && int'(dq.idx) == EW && cpu_ok &&
                               int'(bus_cpu) == c && bus_wdata[EB];
                assign c_clr = wr_enclr && int'(dq.idx) == EW && cpu_ok &&
                               int'(bus_cpu) == c && bus_wdata[EB];
                assign c_ack = ack_vld[c] && (int'(ack_id[c*IDW +: IDW]) == n);
                assign c_eoi = eoi_vld[c] && (int'(eoi_id[c*IDW +: IDW]) == n);

                irqd_src_cell u_cell (
                    .clk       (clk),
                    .rst       (rst),
                    .line_lvl  (line_s[LI]),
                    .line_rise (line_r[LI]),
                    .edge_mode (cfg_edge[n]),
                    .en_set    (c_set),
                    .en_clr    (c_clr),
                    .act_set   (c_ack),
                    .act_clr   (c_eoi),
                    .en_o      (p_en[LI]),
                    .pend_o    (p_pend[LI]),
                    .act_o     (p_act[LI])
                );
                assign cand_o[c*NIRQ + n] = gctl_q & p_en[LI] & p_pend[LI] & ~p_act[LI];
            end
        end else begin : g_shr
            localparam int SJ = n - NPRIV;
            localparam int LI = NCPU * NPRIV + SJ;
            logic [7:0] tg_q;
            logic s_set, s_clr, s_ack, s_eoi;

            always_ff @(posedge clk) begin
                if (rst)                               tg_q <= '0;
                else if (wr_tgt && int'(dq.idx) == BW) tg_q <= bus_wdata[BL +: 8];
            end
            assign tgt_view[n] = tg_q;

            assign s_set = wr_enset && int'(dq.idx) == EW && bus_wdata[EB];
            assign s_clr = wr_enclr && int'(dq.idx) == EW && bus_wdata[EB];

            always_comb begin
                s_ack = 1'b0;
                s_eoi = 1'b0;
                for (int c = 0; c < NCPU; c++) begin
                    if (ack_vld[c] && int'(ack_id[c*IDW +: IDW]) == n) s_ack = 1'b1;
                    if (eoi_vld[c] && int'(eoi_id[c*IDW +: IDW]) == n) s_eoi = 1'b1;
                end
            end

            irqd_src_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .line_lvl  (line_s[LI]),
                .line_rise (line_r[LI]),
                .edge_mode (cfg_edge[n]),
                .en_set    (s_set),
                .en_clr    (s_clr),
                .act_set   (s_ack),
                .act_clr   (s_eoi),
                .en_o      (s_en[SJ]),
                .pend_o    (s_pend[SJ]),
                .act_o     (s_act[SJ])
            );

            for (genvar c = 0; c < NCPU; c++) begin : g_route
                assign cand_o[c*NIRQ + n] =
                    gctl_q & s_en[SJ] & s_pend[SJ] & ~s_act[SJ] & tg_q[c];
            end
        end
    end

    // Processor-relative views: the private half comes from the requester's bank
    always_comb begin
        en_view = '0;
        pd_view = '0;
        ac_view = '0;
        en_view[NIRQ-1:NPRIV] = s_en;
        pd_view[NIRQ-1:NPRIV] = s_pend;
        ac_view[NIRQ-1:NPRIV] = s_act;
        for (int c = 0; c < NCPU; c++) begin
            if (cpu_hot[c]) begin
                en_view[NPRIV-1:0] = p_en[c*NPRIV +: NPRIV];
                pd_view[NPRIV-1:0] = p_pend[c*NPRIV +: NPRIV];
                ac_view[NPRIV-1:0] = p_act[c*NPRIV +: NPRIV];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (dq.sel)
            RG_CTRL: bus_rdata[0] = gctl_q;
            RG_TYPE: bus_rdata[4:0] = 5'(NEW - 1);
            RG_ENSET, RG_ENCLR: begin
                for (int w = 0; w < NEW; w++)
                    if (int'(dq.idx) == w) bus_rdata = en_view[w*32 +: 32];
            end
            RG_PEND: begin
                for (int w = 0; w < NEW; w++)
                    if (int'(dq.idx) == w) bus_rdata = pd_view[w*32 +: 32];
            end
            RG_ACT: begin
                for (int w = 0; w < NEW; w++)
                    if (int'(dq.idx) == w) bus_rdata = ac_view[w*32 +: 32];
            end
            RG_CFG: begin
                for (int w = 0; w < NCW; w++)
                    if (int'(dq.idx) == w)
                        for (int k = 0; k < 16; k++)
                            bus_rdata[2*k+1] = cfg_edge[16*w + k];
            end
            RG_PRIO: begin
                for (int w = 0; w < NBW; w++)
                    if (int'(dq.idx) == w)
                        for (int b = 0; b < 4; b++)
                            bus_rdata[8*b +: 8] = prio_q[4*w + b];
            end
            RG_TGT: begin
                for (int w = 0; w < NBW; w++)
                    if (int'(dq.idx) == w)
                        for (int b = 0; b < 4; b++)
                            bus_rdata[8*b +: 8] = tgt_view[4*w + b];
            end
            default: bus_rdata = '0;
        endcase
    end

    a_r9_gate_blocks_all: assert property (@(posedge clk) disable iff (rst)
        !gctl_q |-> (cand_o == '0));
endmodule

// File: tb/irqd_dist_tb.sv
module irqd_dist_tb;
    localparam int NCPU = 2;
    localparam int NIRQ = 64;
    localparam int NPRIV = 32;
    localparam int IDW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [0:0]  bus_cpu = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU*NPRIV-1:0] priv_in = '0;
    logic [NIRQ-NPRIV-1:0] shr_in = '0;
    logic [NCPU-1:0]       ack_vld = '0;
    logic [NCPU*IDW-1:0]   ack_id = '0;
    logic [NCPU-1:0]       eoi_vld = '0;
    logic [NCPU*IDW-1:0]   eoi_id = '0;
    logic [NCPU*NIRQ-1:0]  cand_o;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rv;

    // Bench model of configuration state for the random phase
    logic [31:0] m_enp [2];
    logic [31:0] m_ens;
    logic [63:0] m_cfg;
    logic [7:0]  m_prio [64];
    logic [7:0]  m_tgt [32];

    always #4 clk = ~clk;

    irqd_dist u_dut (
        .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .priv_in(priv_in), .shr_in(shr_in), .ack_vld(ack_vld), .ack_id(ack_id),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .cand_o(cand_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_cpu = 1'(cpu); bus_addr = 8'(addr); bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int cpu, input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_cpu = 1'(cpu); bus_addr = 8'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic ack(input int cpu, input int id);
        @(negedge clk);
        ack_vld[cpu] = 1'b1; ack_id[cpu*IDW +: IDW] = 6'(id);
        @(negedge clk);
        ack_vld[cpu] = 1'b0;
    endtask

    task automatic eoi(input int cpu, input int id);
        @(negedge clk);
        eoi_vld[cpu] = 1'b1; eoi_id[cpu*IDW +: IDW] = 6'(id);
        @(negedge clk);
        eoi_vld[cpu] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; priv_in = '0; shr_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] f_en(input int cpu, input int w);
        return (w == 0) ? m_enp[cpu] : m_ens;
    endfunction

    function automatic logic [31:0] f_cfg(input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 16; k++) r[2*k+1] = m_cfg[16*w + k];
        return r;
    endfunction

    function automatic logic [31:0] f_prio(input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = m_prio[4*w + b];
        return r;
    endfunction

    function automatic logic [31:0] f_tgt(input int cpu, input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int id = 4*w + b;
            if (id < 32) r[8*b +: 8] = 8'(1 << cpu);
            else         r[8*b +: 8] = m_tgt[id - 32];
        end
        return r;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R13 / R8 / R7: state after reset
        rd(0, 'h00, rv); chk("R13", "control", rv, 32'h0);
        rd(1, 'h01, rv); chk("R8", "type word", rv, 32'h1);
        rd(0, 'h08, rv); chk("R13", "private enables", rv, 32'h0);
        rd(0, 'h09, rv); chk("R13", "shared enables", rv, 32'h0);
        rd(0, 'h21, rv); chk("R13", "config word 1", rv, 32'h0);
        rd(0, 'h48, rv); chk("R13", "priority word 8", rv, 32'h0);
        rd(0, 'h68, rv); chk("R13", "shared target word", rv, 32'h0);
        rd(1, 'h60, rv); chk("R7", "private target cpu1", rv, 32'h02020202);
        rd(0, 'h60, rv); chk("R7", "private target cpu0", rv, 32'h01010101);

        // R1 / R2: set and clear enable words
        wr(0, 'h09, 32'hF0);
        rd(0, 'h09, rv); chk("R1", "set enable", rv, 32'hF0);
        rd(0, 'h0D, rv); chk("R2", "clear word reads enables", rv, 32'hF0);
        wr(0, 'h09, 32'h1);
        rd(0, 'h09, rv); chk("R1", "zero bits keep enables", rv, 32'hF1);
        wr(0, 'h0D, 32'h30);
        rd(0, 'h09, rv); chk("R2", "clear enable", rv, 32'hC1);

        // R6: private enables banked
        wr(0, 'h08, 32'hFFFF0000);
        rd(1, 'h08, rv); chk("R6", "other bank untouched", rv, 32'h0);
        rd(0, 'h08, rv); chk("R6", "own bank written", rv, 32'hFFFF0000);
        rd(1, 'h09, rv); chk("R6", "shared word common", rv, 32'hC1);

        // R3 / R4: configuration fields
        wr(0, 'h20, 32'hFFFFFFFF);
        rd(0, 'h20, rv); chk("R4", "fixed config ignores writes", rv, 32'h0);
        wr(0, 'h21, 32'hFFFFFFFF);
        rd(0, 'h21, rv); chk("R3", "mode bits only", rv, 32'hAAAAAAAA);
        wr(0, 'h21, 32'h0);
        rd(0, 'h21, rv); chk("R3", "mode bits cleared", rv, 32'h0);

        // R5 / R7: priority and target lanes
        wr(0, 'h45, 32'hA1B2C3D4);
        rd(1, 'h45, rv); chk("R5", "priority readback", rv, 32'hA1B2C3D4);
        wr(0, 'h61, 32'hFFFFFFFF);
        rd(0, 'h61, rv); chk("R7", "private target write ignored", rv, 32'h01010101);
        wr(0, 'h6B, 32'h03020100);
        rd(1, 'h6B, rv); chk("R5", "shared target readback", rv, 32'h03020100);

        // Functional: edge id 40 routed to cpu1, level id 41 routed to cpu0
        do_reset();
        wr(0, 'h00, 32'h1);
        wr(0, 'h22, 32'h00020000);
        wr(0, 'h09, 32'h00000300);
        wr(0, 'h6A, 32'h00000102);

        @(negedge clk); shr_in[8] = 1'b1;
        idle(2);
        shr_in[8] = 1'b0;
        idle(5);
        chk("R10", "edge held after line fell", {31'b0, cand_o[64+40]}, 32'h1);
        chk("R12", "unrouted cpu sees nothing", {31'b0, cand_o[40]}, 32'h0);
        rd(0, 'h11, rv); chk("R10", "edge pending read", rv, 32'h100);
        ack(1, 40);
        rd(1, 'h15, rv); chk("R12", "active after ack", rv, 32'h100);
        chk("R12", "no candidate while active", {31'b0, cand_o[64+40]}, 32'h0);
        rd(1, 'h11, rv); chk("R10", "ack clears edge pending", rv, 32'h0);
        eoi(1, 40);
        rd(1, 'h15, rv); chk("R12", "active cleared by completion", rv, 32'h0);
        chk("R10", "no new edge no candidate", {31'b0, cand_o[64+40]}, 32'h0);

        @(negedge clk); shr_in[9] = 1'b1;
        idle(4);
        chk("R11", "level candidate", {31'b0, cand_o[41]}, 32'h1);
        ack(0, 41);
        chk("R11", "level masked while active", {31'b0, cand_o[41]}, 32'h0);
        rd(0, 'h11, rv); chk("R11", "level pending while active", rv, 32'h0);
        eoi(0, 41);
        chk("R11", "level returns after completion", {31'b0, cand_o[41]}, 32'h1);
        wr(0, 'h00, 32'h0);
        chk("R9", "global enable off", cand_o[31:0] | cand_o[63:32] |
            cand_o[95:64] | cand_o[127:96], 32'h0);
        wr(0, 'h00, 32'h1);
        chk("R9", "global enable back on", {31'b0, cand_o[41]}, 32'h1);
        @(negedge clk); shr_in[9] = 1'b0;
        idle(4);
        chk("R11", "level gone with line", {31'b0, cand_o[41]}, 32'h0);

        // R6: private line of cpu1, id 20, enabled in both banks
        wr(1, 'h08, 32'h00100000);
        wr(0, 'h08, 32'h00100000);
        @(negedge clk); priv_in[32+20] = 1'b1;
        idle(4);
        chk("R6", "private candidate own cpu", {31'b0, cand_o[64+20]}, 32'h1);
        chk("R6", "private line not seen by other cpu", {31'b0, cand_o[20]}, 32'h0);
        rd(1, 'h10, rv); chk("R6", "pending in own bank", rv, 32'h00100000);
        rd(0, 'h10, rv); chk("R6", "pending absent in other bank", rv, 32'h0);

        // Random configuration traffic against the model (R1 R2 R3 R4 R5 R6 R7)
        do_reset();
        m_enp[0] = '0; m_enp[1] = '0; m_ens = '0; m_cfg = '0;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
        for (int i = 0; i < 32; i++) m_tgt[i] = '0;
        for (int it = 0; it < 300; it++) begin
            int kind = int'($urandom % 5);
            int cpu = int'($urandom % 2);
            logic [31:0] d = $urandom;
            int w;
            case (kind)
                0: begin
                    w = int'($urandom % 2);
                    wr(cpu, 'h08 + w, d);
                    if (w == 0) m_enp[cpu] = m_enp[cpu] | d; else m_ens = m_ens | d;
                    rd(cpu, 'h0C + w, rv); chk("R1", "random set enable", rv, f_en(cpu, w));
                end
                1: begin
                    w = int'($urandom % 2);
                    wr(cpu, 'h0C + w, d);
                    if (w == 0) m_enp[cpu] = m_enp[cpu] & ~d; else m_ens = m_ens & ~d;
                    rd(cpu, 'h08 + w, rv); chk("R2", "random clear enable", rv, f_en(cpu, w));
                end
                2: begin
                    w = int'($urandom % 4);
                    wr(cpu, 'h20 + w, d);
                    for (int k = 0; k < 16; k++)
                        if (16*w + k >= 16) m_cfg[16*w + k] = d[2*k+1];
                end
                3: begin
                    w = int'($urandom % 16);
                    wr(cpu, 'h40 + w, d);
                    for (int b = 0; b < 4; b++) m_prio[4*w + b] = d[8*b +: 8];
                end
                default: begin
                    w = int'($urandom % 16);
                    wr(cpu, 'h60 + w, d);
                    for (int b = 0; b < 4; b++)
                        if (4*w + b >= 32) m_tgt[4*w + b - 32] = d[8*b +: 8];
                end
            endcase
        end
        for (int cpu = 0; cpu < 2; cpu++) begin
            for (int w = 0; w < 2; w++) begin
                rd(cpu, 'h08 + w, rv); chk("R6", "final enable bank", rv, f_en(cpu, w));
            end
            for (int w = 0; w < 16; w++) begin
                rd(cpu, 'h60 + w, rv); chk("R7", "final target", rv, f_tgt(cpu, w));
            end
        end
        for (int w = 0; w < 4; w++) begin
            rd(0, 'h20 + w, rv); chk("R3", "final config (R4 fixed fields)", rv, f_cfg(w));
        end
        for (int w = 0; w < 16; w++) begin
            rd(1, 'h40 + w, rv); chk("R5", "final priority", rv, f_prio(w));
        end

        summary();
        $finish;
    end
endmodule